// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of N devices on a shared bus may use it. Every device has a local request; the OR of all of them forms a shared request line. A single grant signal enters the chain at the cell nearest the channel (cell 0) and ripples outward. A cell that is not requesting passes the grant on. A requesting cell captures it, becomes the owner and drives the shared busy line until it signals that it has finished. The channel injects a fresh grant only while busy is low.

Two selectable modes decide what happens when the owner finishes. In priority mode the owner simply releases the bus. After one idle cycle, the channel grants again from cell 0, so cells nearer the channel always win. In round-robin mode the finishing cell hands the grant straight to the next cell in index order, wrapping from the last cell to cell 0. If the request line is still active, some requesting cell captures the grant on the same clock edge. If no cell is requesting, the grant is dropped.

Top module: `dchain_arb`

## Requirements
- R1: `req_line` equals the OR of all bits of `req` in the same cycle, with no register in between.
- R2: When `busy` is low and any `req` bit is high, then at the next clock edge `owner` becomes one-hot on the lowest-index requesting cell and `busy` rises. This holds in both modes. Bit i of `owner` is cell i, and cell 0 is nearest the channel.
- R3: While `busy` is high and the owning cell does not assert its `done` bit, `owner` does not change, even if a nearer cell starts requesting.
- R4: `owner` has at most one bit set, and `busy` is high exactly when one bit is set.
- R5: In priority mode (`mode`=0), a `done` from the owner clears `owner` and `busy` at the next edge. The following arbitration restarts from cell 0.
- R6: In round-robin mode (`mode`=1), a `done` from owner k while another cell requests moves ownership at the next edge to the first requesting cell after k in increasing index order. `busy` stays high, with no idle cycle.
- R7: In round-robin mode the search after cell N-1 wraps to cell 0.
- R8: In round-robin mode, a finishing owner that is the only requester gets the grant back. If no `req` bit is high, ownership and `busy` clear at the next edge.
- R9: A `done` bit from a cell that does not own the bus has no effect on `owner` or `busy`.
- R10: While `rst` is high, and after it, `owner` is all zeros and `busy` is low until a request is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = priority, 1 = round-robin |
| req | input | N | Local request of each cell |
| done | input | N | Finish indication of each cell |
| req_line | output | 1 | Shared wired-OR request line |
| owner | output | N | One-hot bus owner, registered |
| busy | output | 1 | Shared busy line, registered |

## Verification
`req_line` is combinational, so the bench checks it 1 ns after it drives `req`, inside the same cycle. `owner` and `busy` are due one clock edge after the inputs that cause them, because the single ownership register in each cell is the only stage on that path. The driver applies inputs on a falling edge and queues the expected state from a reference model. The monitor compares that state at the next falling edge, one full period later, so each comparison lines up with the edge that produced the result.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic {
    ARB_PRIO  = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dchain_ripple.sv
// Grant ripple: one lap from the injection point, plus an optional second
// lap that models the wrap from the last cell back to cell 0.
module dchain_ripple #(
  parameter int N = 4
) (
  input  logic [N-1:0] inject,
  input  logic [N-1:0] req,
  input  logic         wrap,
  output logic [N-1:0] capture
);
  logic [N-1:0] gin0, pass0, gin1, pass1;

  for (genvar i = 0; i < N; i++) begin : g_lap
    if (i == 0) begin : g_head
      assign gin0[i] = inject[i];
      assign gin1[i] = wrap & pass0[N-1];
    end else begin : g_body
      assign gin0[i] = inject[i] | pass0[i-1];
      assign gin1[i] = pass1[i-1];
    end
    assign pass0[i]   = gin0[i] & ~req[i];
    assign pass1[i]   = gin1[i] & ~req[i];
    assign capture[i] = (gin0[i] | gin1[i]) & req[i];
  end
endmodule

// File: rtl/dchain_cell.sv
// One device slot: holds ownership from capture until its own finish.
module dchain_cell (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic done,
  output logic own
);
  always_ff @(posedge clk) begin
    if (rst)       own <= 1'b0;
    else if (take) own <= 1'b1;
    else if (done) own <= 1'b0;
  end
endmodule

// File: rtl/dchain_arb.sv
module dchain_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic         req_line,
  output logic [N-1:0] owner,
  output logic         busy
);
  import dchain_pkg::*;

  localparam logic [N-1:0] HEAD = N'(1);

  arb_mode_e    mode_e;
  logic [N-1:0] own, rot, inject, take;
  logic         fin, idle_start, rr_pass, busy_q, busy_next;

  assign mode_e     = arb_mode_e'(mode);
  assign req_line   = |req;
  assign fin        = |(done & own);
  assign idle_start = ~busy_q & req_line;
  assign rr_pass    = busy_q & fin & (mode_e == ARB_ROUND);

  // Next cell after the owner, with wrap.
  for (genvar i = 0; i < N; i++) begin : g_rot
    assign rot[i] = own[(i + N - 1) % N];
  end

  always_comb begin
    if (idle_start)   inject = HEAD;
    else if (rr_pass) inject = rot;
    else              inject = '0;
  end

  dchain_ripple #(.N(N)) u_ripple (
    .inject  (inject),
    .req     (req),
    .wrap    (rr_pass),
    .capture (take)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    dchain_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .take (take[i]),
      .done (done[i]),
      .own  (own[i])
    );
  end

  assign busy_next = (|take) | (busy_q & ~fin);

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_next;
  end

  assign owner = own;
  assign busy  = busy_q;
endmodule

// File: rtl/dchain_arb_chk.sv
module dchain_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         mode,
  input logic [N-1:0] req,
  input logic [N-1:0] done,
  input logic [N-1:0] owner,
  input logic         busy
);
  // R4
  owner_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner));
  // R4
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (owner != '0));
  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req != '0)) |=> busy);
  // R3
  hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ((done & owner) == '0)) |=> (owner == $past(owner)));
  // R5
  prio_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && busy && ((done & owner) != '0)) |=> !busy);
  // R6
  rr_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && busy && ((done & owner) != '0) && ((req & ~owner) != '0))
    |=> (busy && owner != $past(owner)));
  // R8
  rr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ((done & owner) != '0) && (req == '0)) |=> !busy);
endmodule

bind dchain_arb dchain_arb_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .mode  (mode),
  .req   (req),
  .done  (done),
  .owner (owner),
  .busy  (busy)
);

// File: tb/sim_dchain_arb.sv
`timescale 1ns/1ps
module sim_dchain_arb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic         req_line;
  logic [N-1:0] owner;
  logic         busy;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_own = -1;   // -1 means no owner

  typedef struct {
    logic [N-1:0] own;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  dchain_arb #(.N(N)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .done(done),
    .req_line(req_line), .owner(owner), .busy(busy)
  );

  function automatic int model_next(int cur, logic m, logic [N-1:0] r,
                                    logic [N-1:0] d);
    if (cur < 0) begin
      for (int i = 0; i < N; i++) if (r[i]) return i;
      return -1;
    end
    if (!d[cur]) return cur;
    if (!m) return -1;
    for (int k = 1; k <= N; k++) begin
      int j = (cur + k) % N;
      if (r[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] to_vec(int idx);
    return (idx < 0) ? '0 : (N'(1) << idx);
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic step(logic m, logic [N-1:0] r, logic [N-1:0] d, string tag);
    exp_t e;
    @(negedge clk);
    mode = m; req = r; done = d;
    #1;
    check("R1", {{(N-1){1'b0}}, req_line}, {{(N-1){1'b0}}, |r});
    exp_own = model_next(exp_own, m, r, d);
    e.own = to_vec(exp_own);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare each queued expectation one period after it was driven.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, owner, e.own);
      check(e.tag, {{(N-1){1'b0}}, busy}, {{(N-1){1'b0}}, e.own != '0});
    end
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", owner, '0);
    check("R10", {{(N-1){1'b0}}, busy}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", owner, '0);

    // Priority mode
    step(1'b0, 4'b0110, 4'b0000, "R2 prio lowest requester");
    step(1'b0, 4'b0111, 4'b0000, "R3 nearer request while busy");
    step(1'b0, 4'b0111, 4'b0100, "R9 done from non-owner");
    step(1'b0, 4'b0101, 4'b0010, "R5 prio release");
    step(1'b0, 4'b0101, 4'b0000, "R5 restart from cell 0");
    step(1'b0, 4'b0100, 4'b0001, "R5 release again");
    step(1'b0, 4'b0100, 4'b0000, "R2 next grant");
    step(1'b0, 4'b0100, 4'b0000, "R3 hold");

    // Round-robin mode, owner is cell 2
    step(1'b1, 4'b1101, 4'b0100, "R6 handoff to next requester");
    step(1'b1, 4'b1011, 4'b0000, "R3 hold in round-robin");
    step(1'b1, 4'b1011, 4'b1000, "R7 wrap to cell 0");
    step(1'b1, 4'b0011, 4'b0001, "R6 skip to cell 1");
    step(1'b1, 4'b0010, 4'b0010, "R8 sole requester keeps grant");
    step(1'b1, 4'b0000, 4'b0100, "R9 done from non-owner rr");
    step(1'b1, 4'b0000, 4'b0010, "R8 drop with no request");
    step(1'b1, 4'b1000, 4'b0000, "R2 idle grant in round-robin");
    step(1'b1, 4'b0000, 4'b0000, "R3 hold without request");
    step(1'b1, 4'b0000, 4'b0000, "R3 hold again");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule